// File: doc/BRIEF.md
# Indexed Host Register Port

This block sits between a narrow parallel host bus and a bank of configuration state. One select line tells apart two kinds of host write. A command write loads an 8-bit register index. A data write acts on the register that the index names and then moves the index, so that the host can stream values into consecutive registers without loading a new index each time. Writes step the index by two and data reads step it by one. Three port registers hold the index where it is, so that a burst keeps landing on the same port: the pixel data port, the gamma data port and the filter coefficient data port.

Two lookup tables sit behind index/data register pairs. The gamma table has 256 entries and its pointer wraps. The coefficient table has 32 entries and its pointer stops once it passes the end. Several configuration registers keep only the bits their write mask allows. A divider register stores an offset value. Two 12-bit fields are split across a pair of byte registers. An interrupt status register collects event bits and is cleared by writing zeros to it. A swallow counter can be loaded to discard the next N host accesses, for example while a bridge resynchronises.

The access channel uses valid/ready. `acc_ready` is low during reset and high at all other times, so an access is taken on every clock edge where `acc_valid` is high after reset. A read returns its data on `rsp_valid`/`rsp_rdata` in the cycle after it is accepted. The response has no back-pressure, and the host must take it in that cycle.

Top module: `host_reg_port`

## Requirements
- R1: An accepted access with `acc_write`=1 and `acc_sel`=0 loads `acc_wdata` into the register index. An accepted read with `acc_sel`=0 returns the indexed register and leaves the index unchanged.
- R2: An accepted write with `acc_sel`=1 updates the indexed register, then adds 2 to the index modulo 256. The index is left unchanged when it is 0x90 (pixel data port), 0x5A (coefficient data) or 0xB8 (gamma data).
- R3: An accepted read with `acc_sel`=1 returns the indexed register, then adds 1 to the index modulo 256. There is no exemption for reads.
- R4: `swallow_set` loads `swallow_num` into the swallow counter. While the counter is nonzero, each accepted access decrements it and has no other effect: a write changes nothing, the index included, and a read returns 0 with `rsp_valid`=1.
- R5: Register 0xB6 holds the 8-bit gamma pointer (reset 0). Each read or data write of 0xB8 accesses gamma entry [pointer] and then increments the pointer, wrapping from 255 to 0.
- R6: Register 0x58 holds the coefficient pointer (reset 0). A write to 0x58 keeps only bits 4:0. Each access to 0x5A touches entry [pointer] and increments the pointer only while the pointer is below 32. Once the pointer reaches 32, 0x5A reads 0, writes to it are ignored, and 0x58 reads back 32.
- R7: Register 0xF6 is interrupt status (reset 0). Each bit set in `irq_evt` sets its bit at the next edge. A data write to 0xF6 ANDs the stored value with the written value. When an event arrives in the same cycle as such a write, the event's bit is set.
- R8: Register 0x00 reads 0xA5. Register 0x04 stores written bits 5:0 plus 1, reads back (stored − 1) with bit 7 set, and resets to a stored value of 9, so it reads 0x88 after reset.
- R9: Register 0x08 holds bits 7:0 and register 0x0A holds bits 11:8 (from written bits 3:0) of a 12-bit control field with reset value 0x014. Registers 0x18 and 0x1A do the same for a 12-bit interval field with reset value 0x25C.
- R10: Register 0x68 (mode, reset 0) stores the written value ANDed with 0xB7.
- R11: Every other address, and 0x90, reads 0 and ignores writes.
- R12: `acc_ready` is 0 during reset and 1 afterwards. Every accepted read produces exactly one `rsp_valid` pulse in the next cycle, and writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access accepted when high together with acc_valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = command phase, 1 = data phase |
| acc_wdata | input | 8 | Write value |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 8 | Read data |
| swallow_set | input | 1 | Load the swallow counter |
| swallow_num | input | 4 | Number of accesses to discard |
| irq_evt | input | 8 | Interrupt event bits, one-cycle pulses |

## Verification
The collision of interest is a host write that clears interrupt status landing in the same cycle as a new event on `irq_evt`. The bench drives a clearing write to 0xF6 with event bit 7 raised on that very edge. It then reads the status back through a command-phase read, which does not move the index. The new event bit must survive while the bits masked by the write are cleared. A second collision is a swallow load against pending accesses. The bench checks that swallowed commands, reads and writes change neither the index nor any register, and that normal access resumes on exactly the access after the count runs out.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] A_REV      = 8'h00;
  localparam logic [REG_W-1:0] A_DIV      = 8'h04;
  localparam logic [REG_W-1:0] A_PLL_LO   = 8'h08;
  localparam logic [REG_W-1:0] A_PLL_HI   = 8'h0A;
  localparam logic [REG_W-1:0] A_RFS_LO   = 8'h18;
  localparam logic [REG_W-1:0] A_RFS_HI   = 8'h1A;
  localparam logic [REG_W-1:0] A_COEF_IDX = 8'h58;
  localparam logic [REG_W-1:0] A_COEF_DAT = 8'h5A;
  localparam logic [REG_W-1:0] A_MODE     = 8'h68;
  localparam logic [REG_W-1:0] A_PIXEL    = 8'h90;
  localparam logic [REG_W-1:0] A_GAM_IDX  = 8'hB6;
  localparam logic [REG_W-1:0] A_GAM_DAT  = 8'hB8;
  localparam logic [REG_W-1:0] A_IRQ      = 8'hF6;

  localparam logic [REG_W-1:0] REV_CODE   = 8'hA5;
  localparam logic [REG_W-1:0] MODE_MASK  = 8'hB7;
  localparam logic [6:0]       DIV_RST    = 7'd9;
  localparam logic [11:0]      PLL_RST    = 12'h014;
  localparam logic [11:0]      RFS_RST    = 12'h25C;

  function automatic logic idx_hold(input logic [REG_W-1:0] a);
    return (a == A_PIXEL) || (a == A_COEF_DAT) || (a == A_GAM_DAT);
  endfunction
endpackage

// File: rtl/hrp_index.sv
module hrp_index
  import hrp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             dat_we,
  input  logic             dat_re,
  input  logic [REG_W-1:0] wval,
  output logic [REG_W-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idx_q <= '0;
    else if (cmd_we)                     idx_q <= wval;
    else if (dat_we && !idx_hold(idx_q)) idx_q <= idx_q + REG_W'(2);
    else if (dat_re)                     idx_q <= idx_q + REG_W'(1);
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> idx_q == $past(wval));
  // R2
  idx_step2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !cmd_we && !idx_hold(idx_q)) |=> idx_q == REG_W'($past(idx_q) + REG_W'(2)));
  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !cmd_we && idx_hold(idx_q)) |=> $stable(idx_q));
  // R3
  idx_step1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_re && !cmd_we && !dat_we) |=> idx_q == REG_W'($past(idx_q) + REG_W'(1)));
endmodule

// File: rtl/hrp_table.sv
module hrp_table
  import hrp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit WRAP  = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = WRAP ? AW : AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic             dat_we,
  input  logic             dat_re,
  input  logic [REG_W-1:0] wval,
  output logic [REG_W-1:0] idx_rd,
  output logic [REG_W-1:0] dat_rd
);
  logic [IW-1:0]    ptr;
  logic [REG_W-1:0] mem [DEPTH];
  logic             in_range;

  generate
    if (WRAP) begin : g_wrap
      assign in_range = 1'b1;
    end else begin : g_stop
      assign in_range = (int'(ptr) < DEPTH);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ptr <= '0;
    else if (idx_we)                           ptr <= IW'(wval[AW-1:0]);
    else if ((dat_we || dat_re) && in_range)   ptr <= ptr + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (dat_we && in_range) mem[ptr[AW-1:0]] <= wval;
  end

  assign idx_rd = REG_W'(ptr);
  assign dat_rd = in_range ? mem[ptr[AW-1:0]] : '0;

  // R5 R6
  tbl_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_we || dat_re) && in_range && !idx_we) |=> ptr == IW'($past(ptr) + IW'(1)));
  // R6
  tbl_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_we || dat_re) && !in_range && !idx_we) |=> $stable(ptr));
endmodule

// File: rtl/hrp_cfg.sv
module hrp_cfg
  import hrp_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wval,
  input  logic [IRQ_W-1:0] irq_evt,
  output logic [REG_W-1:0] rdata
);
  logic [6:0]       div_q;
  logic [11:0]      pll_q;
  logic [11:0]      rfs_q;
  logic [REG_W-1:0] mode_q;
  logic [IRQ_W-1:0] irq_q;
  logic             irq_wr;

  assign irq_wr = we && (addr == A_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_RST;
      pll_q  <= PLL_RST;
      rfs_q  <= RFS_RST;
      mode_q <= '0;
    end else if (we) begin
      case (addr)
        A_DIV:    div_q        <= {1'b0, wval[5:0]} + 7'd1;
        A_PLL_LO: pll_q[7:0]   <= wval;
        A_PLL_HI: pll_q[11:8]  <= wval[3:0];
        A_RFS_LO: rfs_q[7:0]   <= wval;
        A_RFS_HI: rfs_q[11:8]  <= wval[3:0];
        A_MODE:   mode_q       <= wval & MODE_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_wr ? (irq_q & wval[IRQ_W-1:0]) : irq_q) | irq_evt;
  end

  always_comb begin
    case (addr)
      A_REV:    rdata = REV_CODE;
      A_DIV:    rdata = REG_W'(div_q - 7'd1) | 8'h80;
      A_PLL_LO: rdata = pll_q[7:0];
      A_PLL_HI: rdata = {4'h0, pll_q[11:8]};
      A_RFS_LO: rdata = rfs_q[7:0];
      A_RFS_HI: rdata = {4'h0, rfs_q[11:8]};
      A_MODE:   rdata = mode_q;
      A_IRQ:    rdata = REG_W'(irq_q);
      default:  rdata = '0;
    endcase
  end

  // R7
  irq_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != '0) |=> ((irq_q & $past(irq_evt)) == $past(irq_evt)));
  // R7
  irq_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt == '0) |=> ((irq_q & ~$past(irq_q)) == '0));
  // R8
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DIV) |=> div_q != 7'd0);
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int SWALLOW_W   = 4,
  parameter int IRQ_W       = 8,
  parameter int GAMMA_DEPTH = 256,
  parameter int COEF_DEPTH  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_write,
  input  logic                 acc_sel,
  input  logic [REG_W-1:0]     acc_wdata,
  output logic                 rsp_valid,
  output logic [REG_W-1:0]     rsp_rdata,
  input  logic                 swallow_set,
  input  logic [SWALLOW_W-1:0] swallow_num,
  input  logic [IRQ_W-1:0]     irq_evt
);
  logic                 ready_q;
  logic [SWALLOW_W-1:0] swal_q;
  logic                 fire, live;
  logic                 cmd_we, dat_we, any_re, dat_re;
  logic [REG_W-1:0]     idx;
  logic [REG_W-1:0]     cfg_rd, gam_idx_rd, gam_dat_rd, cof_idx_rd, cof_dat_rd;
  logic [REG_W-1:0]     rd_mux;

  assign acc_ready = ready_q;
  assign fire   = acc_valid && ready_q;
  assign live   = fire && (swal_q == '0);
  assign cmd_we = live && acc_write && !acc_sel;
  assign dat_we = live && acc_write && acc_sel;
  assign any_re = live && !acc_write;
  assign dat_re = any_re && acc_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    swal_q <= '0;
    else if (swallow_set)          swal_q <= swallow_num;
    else if (fire && swal_q != '0) swal_q <= swal_q - SWALLOW_W'(1);
  end

  hrp_index u_index (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .dat_we(dat_we),
    .dat_re(dat_re), .wval(acc_wdata), .idx_q(idx)
  );

  hrp_table #(.DEPTH(GAMMA_DEPTH), .WRAP(1'b1)) u_gamma (
    .clk(clk), .rst_n(rst_n),
    .idx_we(dat_we && idx == A_GAM_IDX),
    .dat_we(dat_we && idx == A_GAM_DAT),
    .dat_re(any_re && idx == A_GAM_DAT),
    .wval(acc_wdata), .idx_rd(gam_idx_rd), .dat_rd(gam_dat_rd)
  );

  hrp_table #(.DEPTH(COEF_DEPTH), .WRAP(1'b0)) u_coef (
    .clk(clk), .rst_n(rst_n),
    .idx_we(dat_we && idx == A_COEF_IDX),
    .dat_we(dat_we && idx == A_COEF_DAT),
    .dat_re(any_re && idx == A_COEF_DAT),
    .wval(acc_wdata), .idx_rd(cof_idx_rd), .dat_rd(cof_dat_rd)
  );

  hrp_cfg #(.IRQ_W(IRQ_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(dat_we), .addr(idx), .wval(acc_wdata),
    .irq_evt(irq_evt), .rdata(cfg_rd)
  );

  always_comb begin
    case (idx)
      A_GAM_IDX:  rd_mux = gam_idx_rd;
      A_GAM_DAT:  rd_mux = gam_dat_rd;
      A_COEF_IDX: rd_mux = cof_idx_rd;
      A_COEF_DAT: rd_mux = cof_dat_rd;
      default:    rd_mux = cfg_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire && !acc_write;
      rsp_rdata <= any_re ? rd_mux : '0;
    end
  end

  // R4
  swallow_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && swal_q != '0) |=> $stable(idx));
  // R4
  swallow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !acc_write && swal_q != '0) |=> (rsp_valid && rsp_rdata == '0));
  // R12
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_valid && !acc_write)) |=> !rsp_valid);
endmodule

// File: tb/host_reg_port_bench.sv
module host_reg_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic       acc_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic       swallow_set = 1'b0;
  logic [3:0] swallow_num = '0;
  logic [7:0] irq_evt = '0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [6:0]  m_div  = 7'd9;
  logic [11:0] m_pll  = 12'h014;
  logic [11:0] m_rfs  = 12'h25C;
  logic [7:0]  m_mode = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reg_port u_host_reg_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .swallow_set(swallow_set),
    .swallow_num(swallow_num), .irq_evt(irq_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [7:0] last_rd;
  logic       last_rv;

  task automatic acc(input logic w, input logic s, input logic [7:0] d, input logic [7:0] ev);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_sel = s; acc_wdata = d; irq_evt = ev;
    @(negedge clk);
    acc_valid = 1'b0; irq_evt = '0;
    last_rd = rsp_rdata; last_rv = rsp_valid;
  endtask

  task automatic cmd(input logic [7:0] a);  acc(1'b1, 1'b0, a, 8'h00); endtask
  task automatic wr(input logic [7:0] d);   acc(1'b1, 1'b1, d, 8'h00); endtask
  task automatic rd(input logic s);         acc(1'b0, s, 8'h00, 8'h00); endtask

  function automatic logic [7:0] model(input logic [7:0] a);
    case (a)
      8'h00: return 8'hA5;
      8'h04: return 8'(m_div - 7'd1) | 8'h80;
      8'h08: return m_pll[7:0];
      8'h0A: return {4'h0, m_pll[11:8]};
      8'h18: return m_rfs[7:0];
      8'h1A: return {4'h0, m_rfs[11:8]};
      8'h68: return m_mode;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'h04: m_div = {1'b0, v[5:0]} + 7'd1;
      8'h08: m_pll[7:0] = v;
      8'h0A: m_pll[11:8] = v[3:0];
      8'h18: m_rfs[7:0] = v;
      8'h1A: m_rfs[11:8] = v[3:0];
      8'h68: m_mode = v & 8'hB7;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] gval(input int i); return 8'((i * 37 + 11) & 255); endfunction
  function automatic logic [7:0] cval(input int i); return 8'(i * 5 + 1); endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 ready in reset", acc_ready, 0);
    check("R12 no rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready after reset", acc_ready, 1);

    // R1 R8 R9 R10 R11: reset-value sweep with command-phase reads
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h5A || a == 8'hB8) continue;
      cmd(8'(a));
      rd(1'b0);
      check("R11 reset sweep", {last_rv, last_rd}, {1'b1, model(8'(a))});
    end

    // R2 R8 R9 R10 R11: write sweep with masked models
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h5A || a == 8'hB8 || a == 8'h58 || a == 8'hB6 || a == 8'hF6) continue;
      cmd(8'(a));
      wr(8'(a) ^ 8'hC3);
      model_wr(8'(a), 8'(a) ^ 8'hC3);
      cmd(8'(a));
      rd(1'b0);
      check("R10 write sweep", last_rd, model(8'(a)));
    end
    cmd(8'h04); wr(8'h00); m_div = 7'd1;
    cmd(8'h04); rd(1'b0);
    check("R8 divider min", last_rd, 8'h80);

    // R2 step by two, R3 step by one
    cmd(8'h06); wr(8'h11);
    rd(1'b1); check("R2 write step", last_rd, model(8'h08));
    rd(1'b1); check("R3 read step", last_rd, 8'h00);
    rd(1'b1); check("R3 read step 2", last_rd, model(8'h0A));
    cmd(8'hFE); wr(8'h33);
    rd(1'b1); check("R2 wrap", last_rd, 8'hA5);
    cmd(8'hFF); rd(1'b1); rd(1'b1);
    check("R3 wrap", last_rd, 8'hA5);

    // R2 exemption of the pixel data port, seen via gamma pointer 38 reads later
    cmd(8'hB6); wr(8'h44);
    cmd(8'h90); wr(8'h12);
    for (int k = 0; k < 38; k++) begin
      rd(1'b1);
      if (last_rd != 8'h00) check("R11 pixel span", last_rd, 0);
    end
    rd(1'b1);
    check("R2 pixel hold", last_rd, 8'h44);

    // R5 gamma fill, wrap and read back
    cmd(8'hB6); wr(8'h00);
    for (int i = 0; i < 256; i++) wr(gval(i));
    cmd(8'hB6); rd(1'b0);
    check("R5 gamma wrap", last_rd, 0);
    cmd(8'hB8);
    for (int i = 0; i < 256; i++) begin
      rd(1'b0);
      check("R5 gamma data", last_rd, gval(i));
    end
    cmd(8'hB6); wr(8'hFF);
    cmd(8'hB8); rd(1'b0); rd(1'b0);
    check("R5 gamma 255 to 0", last_rd, gval(0));

    // R6 coefficient table
    cmd(8'h58); wr(8'hE3);
    cmd(8'h58); rd(1'b0);
    check("R6 index mask", last_rd, 8'h03);
    cmd(8'h58); wr(8'h00);
    for (int i = 0; i < 34; i++) wr(cval(i));
    cmd(8'h58); rd(1'b0);
    check("R6 index stops", last_rd, 32);
    cmd(8'h5A); rd(1'b0);
    check("R6 past end reads 0", last_rd, 0);
    cmd(8'h58); wr(8'h00);
    cmd(8'h5A);
    for (int i = 0; i < 32; i++) begin
      rd(1'b0);
      check("R6 coef data", last_rd, cval(i));
    end

    // R4 swallow
    @(negedge clk); swallow_set = 1'b1; swallow_num = 4'd3;
    @(negedge clk); swallow_set = 1'b0;
    cmd(8'h04);
    rd(1'b0);
    check("R4 swallowed read", {last_rv, last_rd}, {1'b1, 8'h00});
    wr(8'h3F);
    cmd(8'h04); rd(1'b0);
    check("R4 write ignored", last_rd, model(8'h04));

    // R7 interrupt status and collision with a clear
    @(negedge clk); irq_evt = 8'h0F;
    @(negedge clk); irq_evt = 8'h00;
    cmd(8'hF6); rd(1'b0);
    check("R7 event set", last_rd, 8'h0F);
    acc(1'b1, 1'b1, 8'h03, 8'h80);
    cmd(8'hF6); rd(1'b0);
    check("R7 clear vs event", last_rd, 8'h83);
    wr(8'h00);
    cmd(8'hF6); rd(1'b0);
    check("R7 full clear", last_rd, 8'h00);

    // R12 writes produce no response
    wr(8'h00);
    check("R12 write silent", last_rv, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule